// File: doc/BRIEF.md
# Exception Priority and Debug-Mode Controller

This block sits beside a simple in-order processor pipeline. Every cycle it gathers the pending exception requests: reset, debug, interrupt, fetch-stage, execute-stage and memory-stage requests. It picks the one with the highest fixed priority and reports it one clock later as a registered take pulse with a 5-bit binary cause code. The pipeline uses that pulse to redirect fetch.

The block also tracks the processor mode: run, debug or sleep. Taking a debug-class exception moves it into debug mode. It leaves debug mode on a debug-return request. A sleep request moves it into sleep mode, which drops the core clock enable. The block wakes on reset, NMI, a debug interrupt or an unmasked interrupt.

A software-writable break flag is ORed into the debug interrupt request. The flag clears itself when that debug interrupt is taken.

Top module: `trap_sel_ctrl`

## Requirements
- R1: After `rst_n` is released, `take_o` is 0, `cause_o` is 0, `mode_o` is 0 (run) and `clk_en_o` is 1.
- R2: A reset request (`ext_clear_i` or `por_i`) is taken in any mode, overriding all other requests. It gives `cause_o` = 0 and returns `mode_o` to 0.
- R3: Cause codes follow the priority rank, with 0 the highest: 0 reset, 1 debug single-step, 2 debug interrupt, 3 NMI, 4 interrupt, 5 instruction break, 6 fetch address error, 7 instruction bus error, 8 breakpoint instruction, 9 system call, 10 break instruction, 11 reserved instruction, 12 coprocessor unusable, 13 extension unusable, 14 overflow, 15 trap, 16 data break, 17 load address error, 18 store address error, 19 data bus error, 20 load compare break. `pipe_req_i[k]` requests code k+5. Among the eligible requests, the lowest code is taken.
- R4: When a cycle has an eligible request, `take_o` is 1 after the next rising edge and `cause_o` holds its code. Otherwise `take_o` is 0 after that edge and `cause_o` keeps its previous value.
- R5: The interrupt (code 4) is eligible only while `irq_en_i` is 1. A masked interrupt is ignored.
- R6: The debug interrupt (code 2) is `dbg_irq_i` ORed with a break flag. The flag is written from `brk_wd_i` on an edge where `brk_we_i` is 1. It clears on the edge where code 2 is taken, unless a write happens on that same edge.
- R7: A fetch address error (code 6) and a load address error (code 17) are reported with distinct codes.
- R8: Taking codes 1, 2, 5, 8, 16 or 20 sets `mode_o` to 1 (debug).
- R9: In debug mode only reset and NMI are eligible. Taking an NMI there leaves the mode at debug.
- R10: `dbg_ret_i` in debug mode returns `mode_o` to 0 on the next edge. It has no effect in the other modes.
- R11: `sleep_req_i` in run mode with no eligible request sets `mode_o` to 2 (sleep), and `clk_en_o` goes to 0 after that edge. The request is ignored in debug mode and when an exception is taken on the same edge.
- R12: In sleep mode only reset, NMI, debug interrupt and unmasked interrupt are eligible. Taking one of them leaves sleep mode (to debug for code 2, otherwise to run), and `clk_en_o` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| ext_clear_i | input | 1 | External clear request |
| por_i | input | 1 | Power-on reset request |
| dbg_step_i | input | 1 | Debug single-step request |
| dbg_irq_i | input | 1 | External debug interrupt |
| brk_we_i | input | 1 | Break flag write strobe |
| brk_wd_i | input | 1 | Break flag write value |
| nmi_i | input | 1 | Non-maskable interrupt |
| irq_i | input | 1 | General interrupt request |
| irq_en_i | input | 1 | Interrupt unmask |
| pipe_req_i | input | 16 | Pipeline exception requests, bit k gives code k+5 |
| dbg_ret_i | input | 1 | Debug return request |
| sleep_req_i | input | 1 | Sleep (wait) request |
| take_o | output | 1 | One-cycle registered take pulse |
| cause_o | output | 5 | Binary cause code of the last taken exception |
| mode_o | output | 2 | 0 run, 1 debug, 2 sleep |
| clk_en_o | output | 1 | Core clock enable, low in sleep mode |

## Verification
The priority picker is driven with stacked request sets: all pipeline bits high, all but the top bit high, and pairs that straddle stage boundaries. Each set shows whether the lowest code beats every request ranked below it, and whether the two address-error codes are kept apart. Front-end mixes test each front-end source against everything beneath it: masked and unmasked interrupts, NMI with interrupts, debug interrupt with NMI, and reset over all requests. Directed sequences apply requests that must be blocked while in debug mode and in sleep mode, followed by each wake source. They show whether masking depends on the mode and whether each mode exits to the right place. The break flag is set and then watched across a debug round trip, which tells a self-clearing flag apart from a sticky one.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CAUSE_W = 5;
  localparam int PIPE_N  = 16;
  localparam int FRONT_N = 5;
  localparam int REQ_N   = FRONT_N + PIPE_N;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_DBG   = 2'd1,
    MODE_SLEEP = 2'd2
  } mode_e;

  localparam logic [CAUSE_W-1:0] C_RESET  = 5'd0;
  localparam logic [CAUSE_W-1:0] C_STEP   = 5'd1;
  localparam logic [CAUSE_W-1:0] C_DBGIRQ = 5'd2;
  localparam logic [CAUSE_W-1:0] C_NMI    = 5'd3;
  localparam logic [CAUSE_W-1:0] C_IRQ    = 5'd4;
  localparam logic [CAUSE_W-1:0] C_IBRK   = 5'd5;
  localparam logic [CAUSE_W-1:0] C_BPINS  = 5'd8;
  localparam logic [CAUSE_W-1:0] C_DBRK   = 5'd16;
  localparam logic [CAUSE_W-1:0] C_LDCMP  = 5'd20;

  // Codes whose capture enters debug mode.
  function automatic logic is_debug_code(logic [CAUSE_W-1:0] c);
    return c inside {C_STEP, C_DBGIRQ, C_IBRK, C_BPINS, C_DBRK, C_LDCMP};
  endfunction

  // Codes still accepted while in debug mode.
  function automatic logic kept_in_debug(logic [CAUSE_W-1:0] c);
    return c inside {C_RESET, C_NMI};
  endfunction

  // Codes that may end sleep mode.
  function automatic logic wakes_sleep(logic [CAUSE_W-1:0] c);
    return c inside {C_RESET, C_DBGIRQ, C_NMI, C_IRQ};
  endfunction

  // Index of the lowest set bit; 0 when the vector is empty.
  function automatic logic [CAUSE_W-1:0] lowest_index(logic [REQ_N-1:0] v);
    logic [CAUSE_W-1:0] r;
    r = '0;
    for (int i = REQ_N - 1; i >= 0; i--) begin
      if (v[i]) r = CAUSE_W'(i);
    end
    return r;
  endfunction

  // Mode after one edge, given what was taken and the control requests.
  function automatic mode_e next_mode(mode_e m, logic hit, logic [CAUSE_W-1:0] c,
                                      logic slp, logic ret);
    if (hit && c == C_RESET) return MODE_RUN;
    if (hit && is_debug_code(c)) return MODE_DBG;
    case (m)
      MODE_DBG:   return ret ? MODE_RUN : MODE_DBG;
      MODE_SLEEP: return hit ? MODE_RUN : MODE_SLEEP;
      default:    return (slp && !hit) ? MODE_SLEEP : MODE_RUN;
    endcase
  endfunction
endpackage

// File: rtl/trap_req_gather.sv
module trap_req_gather
  import trap_pkg::*;
#(
  parameter int PN = PIPE_N,
  parameter int RN = FRONT_N + PN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          por_i,
  input  logic          step_i,
  input  logic          dbg_irq_i,
  input  logic          brk_we_i,
  input  logic          brk_wd_i,
  input  logic          nmi_i,
  input  logic          irq_i,
  input  logic          irq_en_i,
  input  logic [PN-1:0] pipe_i,
  input  logic          dbg_irq_taken_i,
  output logic [RN-1:0] raw_o
);
  logic brk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               brk_q <= 1'b0;
    else if (brk_we_i)        brk_q <= brk_wd_i;
    else if (dbg_irq_taken_i) brk_q <= 1'b0;
  end

  assign raw_o = {pipe_i, irq_i & irq_en_i, nmi_i, dbg_irq_i | brk_q, step_i, clr_i | por_i};

  // R6: the flag drops once its debug interrupt has been taken
  a_r6_flag_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_irq_taken_i && !brk_we_i) |=> !brk_q);
endmodule

// File: rtl/trap_gate.sv
module trap_gate
  import trap_pkg::*;
#(
  parameter int N  = REQ_N,
  parameter int CW = CAUSE_W
) (
  input  mode_e        mode_i,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] elig_o
);
  for (genvar i = 0; i < N; i++) begin : g_gate
    localparam logic [CW-1:0] CODE = CW'(i);
    always_comb begin
      case (mode_i)
        MODE_DBG:   elig_o[i] = raw_i[i] & kept_in_debug(CODE);
        MODE_SLEEP: elig_o[i] = raw_i[i] & wakes_sleep(CODE);
        default:    elig_o[i] = raw_i[i];
      endcase
    end
  end
endmodule

// File: rtl/trap_pick.sv
module trap_pick
  import trap_pkg::*;
#(
  parameter int N  = REQ_N,
  parameter int CW = CAUSE_W
) (
  input  logic [N-1:0]  elig_i,
  output logic          valid_o,
  output logic [CW-1:0] code_o
);
  assign valid_o = |elig_i;
  assign code_o  = lowest_index(elig_i);
endmodule

// File: rtl/trap_mode_fsm.sv
module trap_mode_fsm
  import trap_pkg::*;
#(
  parameter int CW = CAUSE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [CW-1:0] code_i,
  input  logic          sleep_req_i,
  input  logic          dbg_ret_i,
  output logic          take_o,
  output logic [CW-1:0] cause_o,
  output mode_e         mode_o,
  output logic          clk_en_o
);
  mode_e mode_d;

  always_comb mode_d = next_mode(mode_o, hit_i, code_i, sleep_req_i, dbg_ret_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o  <= 1'b0;
      cause_o <= '0;
      mode_o  <= MODE_RUN;
    end else begin
      take_o <= hit_i;
      if (hit_i) cause_o <= code_i;
      mode_o <= mode_d;
    end
  end

  assign clk_en_o = (mode_o != MODE_SLEEP);

  // R4: no pick keeps the reported cause
  a_r4_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i |=> $stable(cause_o));
  // R8: debug-class capture enters debug mode
  a_r8_debug_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && is_debug_code(code_i)) |=> (mode_o == MODE_DBG));
  // R9: the picker never offers a debug-class code in debug mode
  a_r9_debug_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_DBG && hit_i) |-> !is_debug_code(code_i));
  // R10: debug return leaves debug mode
  a_r10_debug_return: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_DBG && dbg_ret_i) |=> (mode_o == MODE_RUN));
  // R11: idle sleep request drops the clock enable
  a_r11_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_RUN && sleep_req_i && !hit_i) |=> !clk_en_o);
  // R12: any capture in sleep restores the clock enable
  a_r12_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_SLEEP && hit_i) |=> clk_en_o);
endmodule

// File: rtl/trap_sel_ctrl.sv
module trap_sel_ctrl
  import trap_pkg::*;
#(
  parameter int PN = PIPE_N,
  parameter int CW = CAUSE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_clear_i,
  input  logic          por_i,
  input  logic          dbg_step_i,
  input  logic          dbg_irq_i,
  input  logic          brk_we_i,
  input  logic          brk_wd_i,
  input  logic          nmi_i,
  input  logic          irq_i,
  input  logic          irq_en_i,
  input  logic [PN-1:0] pipe_req_i,
  input  logic          dbg_ret_i,
  input  logic          sleep_req_i,
  output logic          take_o,
  output logic [CW-1:0] cause_o,
  output logic [1:0]    mode_o,
  output logic          clk_en_o
);
  localparam int RN = FRONT_N + PN;

  logic [RN-1:0] raw_req;
  logic [RN-1:0] elig_req;
  logic          pick_hit;
  logic [CW-1:0] pick_code;
  logic          dbg_irq_taken;
  mode_e         mode_q;

  assign dbg_irq_taken = pick_hit && (pick_code == C_DBGIRQ);

  trap_req_gather #(.PN(PN), .RN(RN)) u_gather (
    .clk(clk), .rst_n(rst_n), .clr_i(ext_clear_i), .por_i(por_i),
    .step_i(dbg_step_i), .dbg_irq_i(dbg_irq_i), .brk_we_i(brk_we_i),
    .brk_wd_i(brk_wd_i), .nmi_i(nmi_i), .irq_i(irq_i), .irq_en_i(irq_en_i),
    .pipe_i(pipe_req_i), .dbg_irq_taken_i(dbg_irq_taken), .raw_o(raw_req)
  );

  trap_gate #(.N(RN), .CW(CW)) u_gate (
    .mode_i(mode_q), .raw_i(raw_req), .elig_o(elig_req)
  );

  trap_pick #(.N(RN), .CW(CW)) u_pick (
    .elig_i(elig_req), .valid_o(pick_hit), .code_o(pick_code)
  );

  trap_mode_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hit_i(pick_hit), .code_i(pick_code),
    .sleep_req_i(sleep_req_i), .dbg_ret_i(dbg_ret_i), .take_o(take_o),
    .cause_o(cause_o), .mode_o(mode_q), .clk_en_o(clk_en_o)
  );

  assign mode_o = mode_q;

  // R2: a reset request wins in every mode
  a_r2_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clear_i || por_i) |=> (take_o && cause_o == '0 && mode_o == 2'd0));
  // R5: a masked interrupt alone is never taken
  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !irq_en_i && !ext_clear_i && !por_i && !dbg_step_i && !dbg_irq_i
     && !nmi_i && pipe_req_i == '0 && !(brk_we_i && brk_wd_i) && !take_o
     && mode_q != MODE_DBG) |=> !take_o || cause_o == C_DBGIRQ);
endmodule

// File: tb/sim_trap_sel_ctrl.sv
module sim_trap_sel_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 0, por = 0, step = 0, dext = 0, bwe = 0, bwd = 0;
  logic nmi = 0, irq = 0, irqen = 0, dret = 0, slp = 0;
  logic [15:0] pipe = '0;
  logic take;
  logic [4:0] cause;
  logic [1:0] mode;
  logic clk_en;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  trap_sel_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_clear_i(clr), .por_i(por), .dbg_step_i(step),
    .dbg_irq_i(dext), .brk_we_i(bwe), .brk_wd_i(bwd), .nmi_i(nmi), .irq_i(irq),
    .irq_en_i(irqen), .pipe_req_i(pipe), .dbg_ret_i(dret), .sleep_req_i(slp),
    .take_o(take), .cause_o(cause), .mode_o(mode), .clk_en_o(clk_en)
  );

  // {clr,por,step,dext,nmi,irq,irqen}, pipe, exp take, exp cause, exp mode
  localparam logic [30:0] VEC [17] = '{
    {7'b0000000, 16'h0000, 1'b0, 5'd0,  2'd0},  // idle after reset
    {7'b0000000, 16'hFFFF, 1'b1, 5'd5,  2'd1},  // instruction break top of pipe
    {7'b0000000, 16'hFFFE, 1'b1, 5'd6,  2'd0},  // fetch address error
    {7'b0000000, 16'h0A00, 1'b1, 5'd14, 2'd0},  // overflow over data break
    {7'b0000000, 16'h8000, 1'b1, 5'd20, 2'd1},  // load compare break
    {7'b0000000, 16'h7000, 1'b1, 5'd17, 2'd0},  // load address error
    {7'b0000000, 16'h6000, 1'b1, 5'd18, 2'd0},  // store address error
    {7'b0000010, 16'h0200, 1'b1, 5'd14, 2'd0},  // masked interrupt ignored
    {7'b0000011, 16'hFFFF, 1'b1, 5'd4,  2'd0},  // unmasked interrupt
    {7'b0000111, 16'h0000, 1'b1, 5'd3,  2'd0},  // NMI over interrupt
    {7'b0001100, 16'h0000, 1'b1, 5'd2,  2'd1},  // debug interrupt over NMI
    {7'b0011000, 16'h0000, 1'b1, 5'd1,  2'd1},  // single-step over debug irq
    {7'b0111111, 16'hFFFF, 1'b1, 5'd0,  2'd0},  // power-on over all
    {7'b1000000, 16'h0000, 1'b1, 5'd0,  2'd0},  // external clear
    {7'b0000000, 16'h0008, 1'b1, 5'd8,  2'd1},  // breakpoint instruction
    {7'b0000000, 16'h0010, 1'b1, 5'd9,  2'd0},  // system call
    {7'b0000000, 16'h0000, 1'b0, 5'd9,  2'd0}   // idle keeps cause
  };

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic t, input logic [4:0] c,
                     input logic [1:0] m, input logic ce);
    checks++;
    if (take !== t || cause !== c || mode !== m || clk_en !== ce) begin
      fails++;
      $display("FAIL %s: take/cause/mode/clk_en = %0b/%0d/%0d/%0b expected %0b/%0d/%0d/%0b",
               tag, take, cause, mode, clk_en, t, c, m, ce);
    end
  endtask

  task automatic clear_in();
    {clr, por, step, dext, nmi, irq, irqen, dret, slp, bwe, bwd} = '0;
    pipe = '0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", 1'b0, 5'd0, 2'd0, 1'b1);

    // R3 R4 R5 R7 R8 R2: priority table
    for (int i = 0; i < 17; i++) begin
      {clr, por, step, dext, nmi, irq, irqen} = VEC[i][30:24];
      pipe = VEC[i][23:8];
      cyc();
      chk($sformatf("R3 vector %0d", i), VEC[i][7], VEC[i][6:2], VEC[i][1:0],
          1'b1);
      clear_in();
      dret = 1'b1;
      cyc();
      dret = 1'b0;
    end

    // R6: break flag raises a debug interrupt one edge after the write
    bwe = 1; bwd = 1;
    cyc();
    bwe = 0; bwd = 0;
    chk("R6 flag write edge", 1'b0, 5'd9, 2'd0, 1'b1);
    cyc();
    chk("R6 flag debug irq", 1'b1, 5'd2, 2'd1, 1'b1);
    dret = 1;
    cyc();
    dret = 0;
    chk("R10 return to run", 1'b0, 5'd2, 2'd0, 1'b1);
    cyc();
    chk("R6 flag self-cleared", 1'b0, 5'd2, 2'd0, 1'b1);

    // R9: debug mode masking
    step = 1;
    cyc();
    step = 0;
    chk("R8 step enters debug", 1'b1, 5'd1, 2'd1, 1'b1);
    pipe = 16'h0010; step = 1; dext = 1; irq = 1; irqen = 1;
    cyc();
    clear_in();
    chk("R9 blocked in debug", 1'b0, 5'd1, 2'd1, 1'b1);
    nmi = 1;
    cyc();
    nmi = 0;
    chk("R9 NMI in debug", 1'b1, 5'd3, 2'd1, 1'b1);
    por = 1;
    cyc();
    por = 0;
    chk("R2 reset exits debug", 1'b1, 5'd0, 2'd0, 1'b1);

    dret = 1;
    cyc();
    dret = 0;
    chk("R10 return ignored in run", 1'b0, 5'd0, 2'd0, 1'b1);

    // R11: sleep entry
    slp = 1; pipe = 16'h0010;
    cyc();
    pipe = '0;
    chk("R11 sleep loses to exception", 1'b1, 5'd9, 2'd0, 1'b1);
    cyc();
    slp = 0;
    chk("R11 sleep entered", 1'b0, 5'd9, 2'd2, 1'b0);

    // R12: sleep masking and wake
    pipe = 16'hFFFF; step = 1; irq = 1;
    cyc();
    chk("R12 blocked in sleep", 1'b0, 5'd9, 2'd2, 1'b0);
    irqen = 1;
    cyc();
    clear_in();
    chk("R12 irq wake", 1'b1, 5'd4, 2'd0, 1'b1);
    slp = 1;
    cyc();
    slp = 0;
    chk("R11 sleep again", 1'b0, 5'd4, 2'd2, 1'b0);
    dext = 1;
    cyc();
    dext = 0;
    chk("R12 debug irq wake", 1'b1, 5'd2, 2'd1, 1'b1);
    slp = 1;
    cyc();
    slp = 0;
    chk("R11 sleep ignored in debug", 1'b0, 5'd2, 2'd1, 1'b1);
    dret = 1;
    cyc();
    dret = 0;
    slp = 1;
    cyc();
    slp = 0;
    chk("R11 sleep from run", 1'b0, 5'd2, 2'd2, 1'b0);
    nmi = 1;
    cyc();
    nmi = 0;
    chk("R12 NMI wake", 1'b1, 5'd3, 2'd0, 1'b1);
    slp = 1;
    cyc();
    slp = 0;
    clr = 1;
    cyc();
    clr = 0;
    chk("R2 clear wakes sleep", 1'b1, 5'd0, 2'd0, 1'b1);

    finish_run();
  end
endmodule